// File: doc/BRIEF.md
# Open-Drain Parallel Port with Per-Pin Analog Routing

This block is an 8-bit parallel I/O port whose outputs can only sink current. Each pin is either a general-purpose digital line or an analog converter input. A small register bus holds three registers: an output data latch, a direction register and an analog-select register. A set select bit routes its pin to the converter. Pins that are not selected act as ordinary digital I/O. An output pin whose latch bit is 0 pulls its pad low; otherwise the pad floats and an external pull-up sets the level.

While a pin is routed to the converter, its digital side is kept quiet. Bus writes to that pin's latch and direction bits are dropped. Reads of those bits return 0. Its input sampler is gated off, and it never pulls low. The blocking acts bit by bit, so the other pins keep working as digital lines. The select register is always readable and writable.

Reset is synchronous and active high. It clears the direction and select registers, which leaves every pin a digital input. The data latch keeps its contents through reset.

Top module: `odio_port`

## Requirements
- R1: While reset is high at a clock edge, the direction and select registers clear. From the next cycle, `pull_low` and `ana_conn` are all zero, and reads of address 1 (direction) and address 2 (select) return 0.
- R2: Reset leaves the data latch (address 0) unchanged. A value written before reset is read back and driven once the pin is made an output afterwards.
- R3: Bit n of `ana_conn` equals bit n of the select register (address 2), two cycles after the write to that register. The select register can always be written and read back.
- R4: Bus reads use address 0 for the data, 1 for direction, 2 for select, and 3 returns 0. `reg_rdata` shows the value for the address presented one clock earlier.
- R5: For a digital pin, a read of address 0 returns the sampled pin level when its direction bit is 0. It returns the latch bit when its direction bit is 1. `pin_in` is sampled one clock before it is read.
- R6: Bit n of `pull_low` is 1 only when select bit n is 0, direction bit n is 1 and latch bit n is 0. It follows the registers one cycle after they change.
- R7: When select bit n is 1, writes to bit n of the latch and of the direction register have no effect. Unselected bits in the same write are updated.
- R8: When select bit n is 1, bit n of reads at address 0 and address 1 is 0. Bit n of the sampled input is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 2 | Register address: 0 data, 1 direction, 2 select, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad levels seen by the digital input |
| pull_low | output | 8 | Per-pin drive-low enable for the open-drain pads |
| ana_conn | output | 8 | Per-pin connect to the analog converter |

## Verification
On every cycle the assertions check four things. No pin both pulls low and connects to the converter. A pin pulls low only after its direction bit was set. Masked latch and direction bits stay unchanged across a write. Reads of data and direction show zero on pins routed to the converter. The bench scenarios cover what needs history or pad stimulus:
- the latch surviving reset;
- the two-cycle path from a select write to `ana_conn`;
- a read showing the pad level on inputs and the latch on outputs;
- mixed per-bit masking under random writes.

// File: rtl/odio_pkg.sv
package odio_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 2'd0,
    A_DIR  = 2'd1,
    A_SEL  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/odio_regs.sv
module odio_regs #(
  parameter int unsigned W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [odio_pkg::ADDR_W-1:0]  addr,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 lat_q,
  output logic [W-1:0]                 dir_q,
  output logic [W-1:0]                 sel_q
);
  import odio_pkg::*;

  // merged write value: bits routed to the converter keep their old content
  function automatic logic [W-1:0] masked(input logic [W-1:0] old_v,
                                          input logic [W-1:0] new_v,
                                          input logic [W-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      sel_q <= '0;
    end else if (wr) begin
      if (addr == A_DIR) dir_q <= masked(dir_q, wdata, sel_q);
      if (addr == A_SEL) sel_q <= wdata;
    end
  end

  // data latch has no reset on purpose
  always_ff @(posedge clk) begin
    if (wr && addr == A_DATA) lat_q <= masked(lat_q, wdata, sel_q);
  end
endmodule

// File: rtl/odio_insample.sv
module odio_insample #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] sel_q,
  output logic [W-1:0] pin_q
);
  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_in & ~sel_q;
  end
endmodule

// File: rtl/odio_outstage.sv
module odio_outstage #(
  parameter int unsigned W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [odio_pkg::ADDR_W-1:0]  addr,
  input  logic [W-1:0]                 lat_q,
  input  logic [W-1:0]                 dir_q,
  input  logic [W-1:0]                 sel_q,
  input  logic [W-1:0]                 pin_q,
  output logic [W-1:0]                 rdata,
  output logic [W-1:0]                 pull_low,
  output logic [W-1:0]                 ana_conn
);
  import odio_pkg::*;

  logic [W-1:0] data_view;
  logic [W-1:0] dir_view;
  logic [W-1:0] drv_low;
  logic [W-1:0] rd_next;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign data_view[i] = sel_q[i] ? 1'b0 : (dir_q[i] ? lat_q[i] : pin_q[i]);
    assign dir_view[i]  = dir_q[i] & ~sel_q[i];
    assign drv_low[i]   = ~sel_q[i] & dir_q[i] & ~lat_q[i];
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      A_DATA:  rd_next = data_view;
      A_DIR:   rd_next = dir_view;
      A_SEL:   rd_next = sel_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      pull_low <= '0;
      ana_conn <= '0;
    end else begin
      rdata    <= rd_next;
      pull_low <= drv_low;
      ana_conn <= sel_q;
    end
  end
endmodule

// File: rtl/odio_port.sv
module odio_port #(
  parameter int unsigned W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [odio_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [W-1:0]                 reg_wdata,
  output logic [W-1:0]                 reg_rdata,
  input  logic [W-1:0]                 pin_in,
  output logic [W-1:0]                 pull_low,
  output logic [W-1:0]                 ana_conn
);
  logic [W-1:0] lat_q, dir_q, sel_q, pin_q;

  odio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .lat_q(lat_q), .dir_q(dir_q), .sel_q(sel_q)
  );

  odio_insample #(.W(W)) u_samp (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sel_q(sel_q), .pin_q(pin_q)
  );

  odio_outstage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .addr(reg_addr), .lat_q(lat_q), .dir_q(dir_q),
    .sel_q(sel_q), .pin_q(pin_q), .rdata(reg_rdata), .pull_low(pull_low),
    .ana_conn(ana_conn)
  );
endmodule

// File: rtl/odio_port_chk.sv
module odio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] pull_low,
  input logic [W-1:0] ana_conn,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] sel_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pull_low == '0 && ana_conn == '0));

  // R6
  no_pull_analog_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_low & ana_conn) == '0);

  // R6
  pull_needs_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_low & ~$past(dir_q)) == '0);

  // R7
  dir_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1) |=> ((dir_q ^ $past(dir_q)) & $past(sel_q)) == '0);

  // R7
  lat_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0) |=> ((lat_q ^ $past(lat_q)) & $past(sel_q)) == '0);

  // R8
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd0 || $past(reg_addr) == 2'd1) |-> (reg_rdata & ana_conn) == '0);

  // R4
  unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr) == 2'd3 |-> reg_rdata == '0);
endmodule

bind odio_port odio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pull_low(pull_low), .ana_conn(ana_conn),
  .lat_q(lat_q), .dir_q(dir_q), .sel_q(sel_q)
);

// File: tb/sim_odio_port.sv
`timescale 1ns/1ps
module sim_odio_port;
  localparam int W = 8;
  logic clk = 0, rst = 1, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, pin_in = 0;
  logic [W-1:0] reg_rdata, pull_low, ana_conn;
  int total = 0, bad = 0;
  logic [W-1:0] m_lat, m_dir, m_sel;

  always #2 clk = ~clk;

  odio_port #(.W(W)) u0 (.*);

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a == 2'd0) m_lat = (m_lat & m_sel) | (d & ~m_sel);
    if (a == 2'd1) m_dir = (m_dir & m_sel) | (d & ~m_sel);
    if (a == 2'd2) m_sel = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic logic [W-1:0] exp_data(logic [W-1:0] p);
    return ~m_sel & ((m_dir & m_lat) | (~m_dir & p));
  endfunction

  function automatic logic [W-1:0] exp_pull();
    return ~m_sel & m_dir & ~m_lat;
  endfunction

  task automatic check_all(string tag);
    logic [W-1:0] v;
    @(negedge clk);
    chk({tag, " R3 ana_conn"}, ana_conn, m_sel);
    chk({tag, " R6 pull_low"}, pull_low, exp_pull());
    rd(2'd0, v); chk({tag, " R5/R8 data read"}, v, exp_data(pin_in));
    rd(2'd1, v); chk({tag, " R8 dir read"}, v, m_dir & ~m_sel);
    rd(2'd2, v); chk({tag, " R3 sel read"}, v, m_sel);
    rd(2'd3, v); chk({tag, " R4 unused addr"}, v, '0);
  endtask

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    m_lat = 0; m_dir = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 pull_low", pull_low, '0);
    chk("R1 ana_conn", ana_conn, '0);
    rd(2'd1, v); chk("R1 dir", v, '0);
    rd(2'd2, v); chk("R1 sel", v, '0);
    // R5 input reads pad
    pin_in = 8'hA5; @(negedge clk);
    rd(2'd0, v); chk("R5 input level", v, 8'hA5);
    // R2 latch survives reset
    wr(2'd0, 8'h3C);
    rst = 1; @(negedge clk); rst = 0;
    m_dir = 0; m_sel = 0;
    wr(2'd1, 8'hFF);
    check_all("R2");
    chk("R2 latch kept drive", pull_low, 8'hC3);
    // R7/R8 per-bit blocking
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    check_all("R7");
    wr(2'd2, 8'h00);
    check_all("R7 after release");
    // R3 two-cycle latency of ana_conn
    reg_addr = 2'd2; reg_wdata = 8'h81; reg_wr = 1;
    @(negedge clk); reg_wr = 0; m_sel = 8'h81;
    chk("R3 not yet", ana_conn, 8'h00);
    @(negedge clk);
    chk("R3 arrived", ana_conn, 8'h81);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      wr(a, W'($urandom));
      pin_in = W'($urandom);
      @(negedge clk);
      check_all("RND");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule